// File: doc/BRIEF.md
# Next-PC and Link Unit

This block resolves control flow for a processor with fixed 32-bit instruction words. For every issued instruction it works out the address of the next instruction to fetch. It also works out any write to the link register, and any conditional register-to-register move.

The supported operations are:
- sequential flow;
- conditional branches that compare one register with zero;
- jumps to a target field relative to the upper PC bits;
- jumps through a register;
- the two linking jump forms;
- a move that happens only when a test register is zero.

The decode stage presents the current PC, a 3-bit operation code, the 16-bit offset and 26-bit target fields, and the register-file read values with their indices. The block registers its results once, so they appear on its outputs one clock after the issue strobe. Fetch, the register file and hazard control sit outside the block.

Top module: `npc_link_unit`

## Requirements
- R1: While `rst_n` is low, and in any cycle that follows a clock edge where `issue_i` was low, `vld_o`, `lnk_we_o` and `mov_we_o` are 0. A clock edge with `issue_i` high makes `vld_o` 1 in the following cycle, together with the results for that instruction.
- R2: For op 0 (sequential) and op 7 (conditional move), `npc_o` equals `pc_i` + 4 modulo 2^32.
- R3: For op 1 (branch if zero), `npc_o` is `pc_i` + 4 + sign-extended `off_i` times 4 when the test value is zero, and `pc_i` + 4 otherwise.
- R4: For op 2 (branch if not zero), `npc_o` is `pc_i` + 4 + sign-extended `off_i` times 4 when the test value is non-zero, and `pc_i` + 4 otherwise.
- R5: For op 3 (jump) and op 4 (jump and link), `npc_o` is bits 31..28 of `pc_i` + 4, followed by `tgt_i`, followed by two zero bits.
- R6: For op 5 (register jump) and op 6 (register jump and link), `npc_o` equals the test value.
- R7: Ops 4 and 6 set `lnk_we_o` = 1, `lnk_idx_o` = 31 and `lnk_val_o` = `pc_i` + 4. No other op sets `lnk_we_o`.
- R8: When `rs_idx_i` is 0, the test value is zero whatever `rs_val_i` carries.
- R9: For op 7, `mov_we_o` is 1 exactly when the test value is zero and `rd_idx_i` is not 0. In that case `mov_idx_o` = `rd_idx_i` and `mov_val_o` = `rt_val_i`. Every other op, and a move to index 0, gives `mov_we_o` = 0.
- R10: `lnk_we_o` and `mov_we_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| op_i | input | 3 | Operation code (0..7 as listed in the requirements) |
| pc_i | input | 32 | Address of the instruction |
| off_i | input | 16 | Branch offset in instruction words |
| tgt_i | input | 26 | Jump target field |
| rs_idx_i | input | 5 | Index of the test/jump register |
| rs_val_i | input | 32 | Value read for the test/jump register |
| rt_val_i | input | 32 | Source value of the conditional move |
| rd_idx_i | input | 5 | Destination index of the conditional move |
| vld_o | output | 1 | Results below belong to the instruction issued last cycle |
| npc_o | output | 32 | Next program counter |
| lnk_we_o | output | 1 | Link register write enable |
| lnk_idx_o | output | 5 | Link register index |
| lnk_val_o | output | 32 | Return address to write |
| mov_we_o | output | 1 | Conditional move write enable |
| mov_idx_o | output | 5 | Conditional move destination |
| mov_val_o | output | 32 | Conditional move data |

## Verification
All state lives in the single result register, and it is exposed one cycle after each issue. A wrong select, zero test or offset scaling therefore shows as a wrong `npc_o` or enable in the very next cycle, on the instruction that caused it. A stale enable would show as a write strobe in an idle cycle. A register-0 test error appears only when a non-zero value is offered with index 0, so the stimulus pairs that index with non-zero data. Branch offsets cover both signs, and PC values near the top of the address space exercise wrap-around and the kept upper bits.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    OP_SEQ   = 3'd0,
    OP_BRZ   = 3'd1,
    OP_BRNZ  = 3'd2,
    OP_JMP   = 3'd3,
    OP_JMPL  = 3'd4,
    OP_JREG  = 3'd5,
    OP_JREGL = 3'd6,
    OP_MOVZ  = 3'd7
  } npc_op_e;
endpackage

// File: rtl/npc_zero_test.sv
module npc_zero_test #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic [RIDX-1:0] idx_i,
  input  logic [XLEN-1:0] val_i,
  output logic [XLEN-1:0] eff_o,
  output logic            zero_o
);
  // index 0 is the hard-wired zero register
  always_comb begin
    eff_o  = (idx_i == '0) ? '0 : val_i;
    zero_o = (eff_o == '0);
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  parameter int TGTW = 26
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [TGTW-1:0] tgt_i,
  output logic [XLEN-1:0] seq_o,
  output logic [XLEN-1:0] br_o,
  output logic [XLEN-1:0] jmp_o
);
  localparam int          SEXT  = XLEN - OFFW - 2;
  localparam int          KEEP  = XLEN - TGTW - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] disp;

  always_comb begin
    seq_o = pc_i + STEP;
    disp  = {{SEXT{off_i[OFFW-1]}}, off_i, 2'b00};
    br_o  = seq_o + disp;
  end

  generate
    if (KEEP > 0) begin : g_keep
      assign jmp_o = {seq_o[XLEN-1 -: KEEP], tgt_i, 2'b00};
    end else begin : g_full
      assign jmp_o = {tgt_i[XLEN-3:0], 2'b00};
    end
  endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select #(
  parameter int XLEN = 32
) (
  input  npc_pkg::npc_op_e op_i,
  input  logic             zero_i,
  input  logic [XLEN-1:0]  seq_i,
  input  logic [XLEN-1:0]  br_i,
  input  logic [XLEN-1:0]  jmp_i,
  input  logic [XLEN-1:0]  reg_i,
  output logic [XLEN-1:0]  npc_o,
  output logic             link_o,
  output logic             move_o
);
  import npc_pkg::*;

  always_comb begin
    npc_o  = seq_i;
    link_o = 1'b0;
    move_o = 1'b0;
    unique case (op_i)
      OP_BRZ:   npc_o = zero_i ? br_i : seq_i;
      OP_BRNZ:  npc_o = zero_i ? seq_i : br_i;
      OP_JMP:   npc_o = jmp_i;
      OP_JMPL:  begin npc_o = jmp_i; link_o = 1'b1; end
      OP_JREG:  npc_o = reg_i;
      OP_JREGL: begin npc_o = reg_i; link_o = 1'b1; end
      OP_MOVZ:  move_o = zero_i;
      default:  npc_o = seq_i;
    endcase
  end
endmodule

// File: rtl/npc_link_unit.sv
module npc_link_unit #(
  parameter int XLEN     = 32,
  parameter int OFFW     = 16,
  parameter int TGTW     = 26,
  parameter int RIDX     = 5,
  parameter int LINK_REG = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [TGTW-1:0] tgt_i,
  input  logic [RIDX-1:0] rs_idx_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  input  logic [RIDX-1:0] rd_idx_i,
  output logic            vld_o,
  output logic [XLEN-1:0] npc_o,
  output logic            lnk_we_o,
  output logic [RIDX-1:0] lnk_idx_o,
  output logic [XLEN-1:0] lnk_val_o,
  output logic            mov_we_o,
  output logic [RIDX-1:0] mov_idx_o,
  output logic [XLEN-1:0] mov_val_o
);
  import npc_pkg::*;

  localparam logic [RIDX-1:0] LINK_IDX = RIDX'(LINK_REG);

  npc_op_e         op;
  logic [XLEN-1:0] rs_eff, seq_pc, br_pc, jmp_pc, npc_c;
  logic            rs_zero, link_req, move_req, link_ok;
  logic            vld_d, lnk_we_d, mov_we_d;

  assign op = npc_op_e'(op_i);

  npc_zero_test #(.XLEN(XLEN), .RIDX(RIDX)) u_zt (
    .idx_i(rs_idx_i), .val_i(rs_val_i), .eff_o(rs_eff), .zero_o(rs_zero)
  );

  npc_target #(.XLEN(XLEN), .OFFW(OFFW), .TGTW(TGTW)) u_tg (
    .pc_i(pc_i), .off_i(off_i), .tgt_i(tgt_i),
    .seq_o(seq_pc), .br_o(br_pc), .jmp_o(jmp_pc)
  );

  npc_select #(.XLEN(XLEN)) u_sel (
    .op_i(op), .zero_i(rs_zero), .seq_i(seq_pc), .br_i(br_pc),
    .jmp_i(jmp_pc), .reg_i(rs_eff),
    .npc_o(npc_c), .link_o(link_req), .move_o(move_req)
  );

  // a link aimed at the zero register can never write
  generate
    if (LINK_REG == 0) begin : g_nolink
      assign link_ok = 1'b0;
    end else begin : g_link
      assign link_ok = 1'b1;
    end
  endgenerate

  // next-state
  always_comb begin
    vld_d    = issue_i;
    lnk_we_d = issue_i & link_req & link_ok;
    mov_we_d = issue_i & move_req & (rd_idx_i != '0);
  end

  // control register, async reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o    <= 1'b0;
      lnk_we_o <= 1'b0;
      mov_we_o <= 1'b0;
    end else begin
      vld_o    <= vld_d;
      lnk_we_o <= lnk_we_d;
      mov_we_o <= mov_we_d;
    end
  end

  // data register, clock-enabled by issue
  always_ff @(posedge clk) begin
    if (issue_i) begin
      npc_o     <= npc_c;
      lnk_idx_o <= LINK_IDX;
      lnk_val_o <= seq_pc;
      mov_idx_o <= rd_idx_i;
      mov_val_o <= rt_val_i;
    end
  end
endmodule

// File: rtl/npc_link_chk.sv
module npc_link_chk #(
  parameter int XLEN     = 32,
  parameter int RIDX     = 5,
  parameter int LINK_REG = 31
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_i,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] pc_i,
  input logic [RIDX-1:0] rs_idx_i,
  input logic            vld_o,
  input logic [XLEN-1:0] npc_o,
  input logic            lnk_we_o,
  input logic [RIDX-1:0] lnk_idx_o,
  input logic [XLEN-1:0] lnk_val_o,
  input logic            mov_we_o,
  input logic [RIDX-1:0] mov_idx_o
);
  a_r1_issue_valid: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> vld_o);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> (!lnk_we_o && !mov_we_o));

  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && $past(op_i) == 3'd0) |-> npc_o == $past(pc_i) + XLEN'(4));

  a_r7_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_we_o |-> (lnk_idx_o == RIDX'(LINK_REG) && lnk_val_o == $past(pc_i) + XLEN'(4)));

  a_r8_zero_index: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && $past(op_i) == 3'd5 && $past(rs_idx_i) == '0) |-> npc_o == '0);

  a_r9_move_dest: assert property (@(posedge clk) disable iff (!rst_n)
    mov_we_o |-> (mov_idx_o != '0 && $past(op_i) == 3'd7));

  a_r10_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lnk_we_o, mov_we_o}) <= 1);
endmodule

bind npc_link_unit npc_link_chk #(.XLEN(XLEN), .RIDX(RIDX), .LINK_REG(LINK_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i), .pc_i(pc_i),
  .rs_idx_i(rs_idx_i), .vld_o(vld_o), .npc_o(npc_o), .lnk_we_o(lnk_we_o),
  .lnk_idx_o(lnk_idx_o), .lnk_val_o(lnk_val_o), .mov_we_o(mov_we_o),
  .mov_idx_o(mov_idx_o)
);

// File: tb/sim_npc_link_unit.sv
module sim_npc_link_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i;
  logic [2:0]  op_i;
  logic [31:0] pc_i, rs_val_i, rt_val_i;
  logic [15:0] off_i;
  logic [25:0] tgt_i;
  logic [4:0]  rs_idx_i, rd_idx_i;
  logic        vld_o, lnk_we_o, mov_we_o;
  logic [31:0] npc_o, lnk_val_o, mov_val_o;
  logic [4:0]  lnk_idx_o, mov_idx_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_link_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i), .pc_i(pc_i),
    .off_i(off_i), .tgt_i(tgt_i), .rs_idx_i(rs_idx_i), .rs_val_i(rs_val_i),
    .rt_val_i(rt_val_i), .rd_idx_i(rd_idx_i), .vld_o(vld_o), .npc_o(npc_o),
    .lnk_we_o(lnk_we_o), .lnk_idx_o(lnk_idx_o), .lnk_val_o(lnk_val_o),
    .mov_we_o(mov_we_o), .mov_idx_o(mov_idx_o), .mov_val_o(mov_val_o)
  );

  typedef struct {
    string       req;
    logic [31:0] npc;
    logic        lwe;
    logic [31:0] lval;
    logic        mwe;
    logic [4:0]  midx;
    logic [31:0] mval;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] op, input logic [31:0] pc,
                                 input logic [15:0] off, input logic [25:0] tgt,
                                 input logic [4:0] rsi, input logic [31:0] rsv,
                                 input logic [31:0] rtv, input logic [4:0] rdi,
                                 input string req);
    exp_t e;
    logic [31:0] t, nxt, taken;
    int signed   words;
    t     = (rsi == 5'd0) ? 32'd0 : rsv;
    nxt   = pc + 32'd4;
    words = int'($signed(off));
    taken = nxt + 32'(words * 4);
    e.req  = req;
    e.lwe  = (op == 3'd4) || (op == 3'd6);
    e.lval = nxt;
    e.mwe  = (op == 3'd7) && (t == 32'd0) && (rdi != 5'd0);
    e.midx = rdi;
    e.mval = rtv;
    case (op)
      3'd1:       e.npc = (t == 0) ? taken : nxt;
      3'd2:       e.npc = (t != 0) ? taken : nxt;
      3'd3, 3'd4: e.npc = {nxt[31:28], tgt, 2'b00};
      3'd5, 3'd6: e.npc = t;
      default:    e.npc = nxt;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [2:0] op, input logic [31:0] pc, input logic [15:0] off,
                       input logic [25:0] tgt, input logic [4:0] rsi, input logic [31:0] rsv,
                       input logic [31:0] rtv, input logic [4:0] rdi, input string req);
    @(negedge clk);
    issue_i = 1'b1; op_i = op; pc_i = pc; off_i = off; tgt_i = tgt;
    rs_idx_i = rsi; rs_val_i = rsv; rt_val_i = rtv; rd_idx_i = rdi;
    exp_q.push_back(model(op, pc, off, tgt, rsi, rsv, rtv, rdi, req));
  endtask

  // monitor: compare each result against the oldest expectation
  always @(negedge clk) begin
    #1;
    if (rst_n && vld_o) begin
      if (exp_q.size() == 0) begin
        chk("R1 unexpected vld_o", {31'd0, vld_o}, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.req, " npc_o"}, npc_o, e.npc);
        chk({e.req, " R7 lnk_we_o"}, {31'd0, lnk_we_o}, {31'd0, e.lwe});
        if (e.lwe) begin
          chk({e.req, " R7 lnk_idx_o"}, {27'd0, lnk_idx_o}, 32'd31);
          chk({e.req, " R7 lnk_val_o"}, lnk_val_o, e.lval);
        end
        chk({e.req, " R9 mov_we_o"}, {31'd0, mov_we_o}, {31'd0, e.mwe});
        if (e.mwe) begin
          chk({e.req, " R9 mov_idx_o"}, {27'd0, mov_idx_o}, {27'd0, e.midx});
          chk({e.req, " R9 mov_val_o"}, mov_val_o, e.mval);
        end
        chk({e.req, " R10 one write"}, {31'd0, lnk_we_o & mov_we_o}, 32'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; issue_i = 1'b0; op_i = '0; pc_i = '0; off_i = '0; tgt_i = '0;
    rs_idx_i = '0; rs_val_i = '0; rt_val_i = '0; rd_idx_i = '0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset vld_o", {31'd0, vld_o}, 32'd0);
    chk("R1 reset lnk_we_o", {31'd0, lnk_we_o}, 32'd0);
    chk("R1 reset mov_we_o", {31'd0, mov_we_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    drive(3'd0, 32'h0000_1000, 16'h0, 26'h0, 5'd3, 32'h5, 32'h0, 5'd0, "R2 seq");
    drive(3'd0, 32'hFFFF_FFFC, 16'h0, 26'h0, 5'd3, 32'h5, 32'h0, 5'd0, "R2 seq wrap");
    drive(3'd1, 32'h0000_2000, 16'h0010, 26'h0, 5'd4, 32'h0, 32'h0, 5'd0, "R3 brz taken fwd");
    drive(3'd1, 32'h0000_2000, 16'hFFF0, 26'h0, 5'd4, 32'h0, 32'h0, 5'd0, "R3 brz taken back");
    drive(3'd1, 32'h0000_2000, 16'h0010, 26'h0, 5'd4, 32'h1, 32'h0, 5'd0, "R3 brz not taken");
    drive(3'd2, 32'h0000_3000, 16'h8000, 26'h0, 5'd4, 32'h7, 32'h0, 5'd0, "R4 brnz taken min");
    drive(3'd2, 32'h0000_3000, 16'h7FFF, 26'h0, 5'd4, 32'h0, 32'h0, 5'd0, "R4 brnz not taken");
    drive(3'd1, 32'h0000_4000, 16'h0020, 26'h0, 5'd0, 32'hDEAD_BEEF, 32'h0, 5'd0, "R8 brz idx0 taken");
    drive(3'd2, 32'h0000_4000, 16'h0020, 26'h0, 5'd0, 32'hDEAD_BEEF, 32'h0, 5'd0, "R8 brnz idx0 not taken");
    drive(3'd3, 32'hA000_0010, 16'h0, 26'h3FF_FFFF, 5'd0, 32'h0, 32'h0, 5'd0, "R5 jump");
    drive(3'd3, 32'hEFFF_FFFC, 16'h0, 26'h000_0001, 5'd0, 32'h0, 32'h0, 5'd0, "R5 jump carry upper");
    drive(3'd4, 32'h1234_5678, 16'h0, 26'h012_3456, 5'd0, 32'h0, 32'h0, 5'd0, "R5 R7 jump link");
    drive(3'd5, 32'h0000_5000, 16'h0, 26'h0, 5'd9, 32'h0000_8888, 32'h0, 5'd0, "R6 jump reg");
    drive(3'd5, 32'h0000_5000, 16'h0, 26'h0, 5'd0, 32'h0000_8888, 32'h0, 5'd0, "R8 jump reg idx0");
    drive(3'd6, 32'h0000_6000, 16'h0, 26'h0, 5'd31, 32'h0000_0400, 32'h0, 5'd0, "R6 R7 jump reg link");
    drive(3'd7, 32'h0000_7000, 16'h0, 26'h0, 5'd2, 32'h0, 32'hCAFE_F00D, 5'd12, "R9 move zero");
    drive(3'd7, 32'h0000_7000, 16'h0, 26'h0, 5'd2, 32'h1, 32'hCAFE_F00D, 5'd12, "R9 move held");
    drive(3'd7, 32'h0000_7000, 16'h0, 26'h0, 5'd2, 32'h0, 32'hCAFE_F00D, 5'd0, "R9 move to r0");
    drive(3'd7, 32'h0000_7000, 16'h0, 26'h0, 5'd0, 32'h55, 32'h1111_2222, 5'd7, "R8 R9 move idx0");

    for (int i = 0; i < 80; i++) begin
      logic [4:0] ri;
      ri = (i % 5 == 0) ? 5'd0 : 5'($urandom);
      drive(3'($urandom), $urandom, 16'($urandom), 26'($urandom), ri,
            (i % 3 == 0) ? 32'd0 : $urandom, $urandom, 5'($urandom), "R2-mix");
    end

    @(negedge clk);
    issue_i = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    chk("R1 idle vld_o", {31'd0, vld_o}, 32'd0);
    chk("R1 idle lnk_we_o", {31'd0, lnk_we_o}, 32'd0);
    chk("R1 idle mov_we_o", {31'd0, mov_we_o}, 32'd0);
    chk("R1 all results seen", exp_q.size(), 32'd0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule